// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block produces the serial clock for an SPI master from the module clock. It supports two divide laws, and a select bit in the control word chooses between them. In linear mode the serial clock period is 2*(N+1) module clock cycles, where N is an 8-bit field. In power-of-two mode the period is 2^(M+1) cycles, where M is a 4-bit field. Power-of-two mode reaches the slow rates that the narrow linear field cannot reach.

The transfer engine raises an enable for the length of a transfer. On the first clock edge at which the enable is seen high, the block latches the control word. From then on it toggles the serial clock after each half period. Each toggle comes with a one-cycle pulse. The leading pulse marks the rising edge and the trailing pulse marks the falling edge, and a shifter uses them to sample and launch data. While the enable is low, the serial clock rests low. Clock polarity is applied outside this block.

Top module: `spi_sclk_divider`

## Requirements
- R1: While rst_ni is low, and on every cycle while en_i has been low, sclk_o, lead_o and trail_o are 0.
- R2: Linear mode is selected by ctrl_i[12] = 1. In this mode sclk_o has a period of 2*(N+1) module clock cycles, with N+1 cycles high and N+1 cycles low.
- R3: Power-of-two mode is selected by ctrl_i[12] = 0. In this mode sclk_o has a period of 2^(M+1) cycles, with 2^M cycles high and 2^M cycles low.
- R4: In linear mode with N = 0, sclk_o toggles on every module clock edge, which divides the module clock by 2.
- R5: Let H be the half period. Count the rising clock edges at which en_i is sampled high, starting at 1. sclk_o first rises at edge H+1 and then toggles every H edges.
- R6: lead_o is a one-cycle pulse in exactly the cycles where sclk_o has just risen. trail_o is a one-cycle pulse in exactly the cycles where sclk_o has just fallen while enabled. The two are never high together.
- R7: At the first clock edge at which en_i is sampled low, sclk_o returns to 0 even if it was high, and no pulse is produced. The next enable starts again from R5.
- R8: The control word is sampled only at the first enabled edge. Changes to ctrl_i while en_i stays high have no effect on sclk_o until the next rise of en_i.
- R9: N is ctrl_i[7:0] and M is ctrl_i[11:8]. The field that the mode bit does not select has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transfer enable from the transfer engine |
| ctrl_i | input | 13 | Control word: {mode, M[3:0], N[7:0]} |
| sclk_o | output | 1 | Serial clock level, idle 0 |
| lead_o | output | 1 | One-cycle pulse on the rising edge of sclk_o |
| trail_o | output | 1 | One-cycle pulse on the falling edge of sclk_o |

## Verification
The assertions check on every cycle the following behaviours:
- sclk_o is idle whenever the enable is low.
- Each pulse coincides with the matching sclk_o transition, every rise of sclk_o carries a leading pulse, and the two pulses never overlap.
- The latched divider setting holds steady for the whole of an enabled run.

Some behaviours only the bench scenarios can show, because they depend on the arithmetic value of the divide law. These are the exact half-period length under each law, the offset of the first edge, the fastest linear rate, the unused field being ignored, and mid-transfer control changes being deferred. To show them, the bench sweeps both fields and compares every cycle against a computed edge schedule.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  typedef enum logic {
    DIV_EXP = 1'b0,
    DIV_LIN = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
  import spi_div_pkg::*;
#(
  parameter int LIN_W   = 8,
  parameter int EXP_W   = 4,
  parameter int EXP_LSB = 8,
  parameter int CTRL_W  = 13,
  parameter int CNT_W   = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              running_o,
  output logic [CNT_W-1:0]  half_m1_o
);
  localparam int MODE_BIT = EXP_LSB + EXP_W;

  logic [LIN_W-1:0] lin_val;
  logic [EXP_W-1:0] exp_val;
  div_mode_e        mode;
  logic [CNT_W-1:0] half_m1_d;

  assign lin_val = ctrl_i[LIN_W-1:0];
  assign exp_val = ctrl_i[EXP_LSB +: EXP_W];
  assign mode    = div_mode_e'(ctrl_i[MODE_BIT]);

  // Half period minus one: N for linear, 2^M - 1 for power-of-two
  always_comb begin
    if (mode == DIV_LIN) half_m1_d = CNT_W'(lin_val);
    else                 half_m1_d = (CNT_W'(1) << exp_val) - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_o <= 1'b0;
      half_m1_o <= '0;
    end else if (!en_i) begin
      running_o <= 1'b0;
    end else if (!running_o) begin
      running_o <= 1'b1;
      half_m1_o <= half_m1_d;
    end
  end
endmodule

// File: rtl/spi_div_counter.sv
module spi_div_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             running_i,
  input  logic [CNT_W-1:0] half_m1_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = running_i && (cnt_q == half_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!en_i || !running_i)   cnt_q <= '0;
    else if (tick_o)                cnt_q <= '0;
    else                            cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_div_edge.sv
module spi_div_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!en_i) begin
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (tick_i) begin
      sclk_o  <= ~sclk_o;
      lead_o  <= ~sclk_o;
      trail_o <= sclk_o;
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int LIN_W   = 8,
  parameter int EXP_W   = 4,
  parameter int EXP_LSB = 8,
  localparam int CTRL_W   = EXP_LSB + EXP_W + 1,
  localparam int EXP_SPAN = (1 << EXP_W) - 1,
  localparam int CNT_W    = (LIN_W > EXP_SPAN) ? LIN_W : EXP_SPAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              sclk_o,
  output logic              lead_o,
  output logic              trail_o
);
  logic             running;
  logic [CNT_W-1:0] half_m1;
  logic             tick;

  spi_div_cfg #(
    .LIN_W(LIN_W), .EXP_W(EXP_W), .EXP_LSB(EXP_LSB),
    .CTRL_W(CTRL_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ctrl_i(ctrl_i),
    .running_o(running), .half_m1_o(half_m1)
  );

  spi_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .running_i(running),
    .half_m1_i(half_m1), .tick_o(tick)
  );

  spi_div_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick),
    .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );
endmodule

// File: rtl/spi_sclk_divider_chk.sv
module spi_sclk_divider_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             sclk_o,
  input logic             lead_o,
  input logic             trail_o,
  input logic             running,
  input logic [CNT_W-1:0] half_m1
);
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sclk_o && !lead_o && !trail_o));

  p_lead_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> $rose(sclk_o));

  p_trail_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> $fell(sclk_o));

  p_rise_has_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> lead_o);

  p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $past(running)) |-> $stable(half_m1));
endmodule

bind spi_sclk_divider spi_sclk_divider_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sclk_o(sclk_o),
  .lead_o(lead_o), .trail_o(trail_o), .running(running), .half_m1(half_m1)
);

// File: tb/sim_spi_sclk_divider.sv
`timescale 1ns/1ps
module sim_spi_sclk_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [12:0] ctrl_i = '0;
  logic        sclk_o, lead_o, trail_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  spi_sclk_divider u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ctrl_i(ctrl_i),
    .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  function automatic logic [12:0] mk(input logic lin, input int m, input int n);
    return {lin, 4'(m), 8'(n)};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic idle_chk(input int cycles);
    en_i = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R7 sclk idle", sclk_o, 1'b0);
      chk("R7 lead idle", lead_o, 1'b0);
      chk("R7 trail idle", trail_o, 1'b0);
    end
  endtask

  // Run with half period h; optionally swap ctrl mid-run (R8)
  task automatic run(input string tag, input logic [12:0] cw, input int h,
                     input int swap_at, input logic [12:0] cw2);
    logic es;
    int   ph;
    ctrl_i = cw;
    @(negedge clk_i);
    en_i = 1'b1;
    for (int k = 1; k <= 5 * h + 1; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      ph = (k - 1) / h;
      es = ph[0];
      chk((k <= h + 1) ? "R5 first edge" : tag, sclk_o, es);
      chk("R6 lead", lead_o, (k > 1) && ((k - 1) % h == 0) && es);
      chk("R6 trail", trail_o, (k > 1) && ((k - 1) % h == 0) && !es);
      if (k == swap_at) ctrl_i = cw2;
    end
    // ends with sclk high; drop enable
    idle_chk(2);
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 sclk reset", sclk_o, 1'b0);
    chk("R1 lead reset", lead_o, 1'b0);
    chk("R1 trail reset", trail_o, 1'b0);
    rst_ni = 1'b1;
    ctrl_i = mk(1'b1, 0, 0);
    repeat (3) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R1 sclk idle", sclk_o, 1'b0);
      chk("R1 lead idle", lead_o | trail_o, 1'b0);
    end

    run("R4 div2", mk(1'b1, 0, 0), 1, 0, '0);
    for (int n = 1; n <= 9; n++) run("R2 linear", mk(1'b1, 0, n), n + 1, 0, '0);
    run("R2 linear max", mk(1'b1, 0, 255), 256, 0, '0);
    for (int m = 0; m <= 6; m++) run("R3 pow2", mk(1'b0, m, 0), 1 << m, 0, '0);
    run("R3 pow2 m10", mk(1'b0, 10, 0), 1024, 0, '0);
    run("R9 lin ignores M", mk(1'b1, 15, 3), 4, 0, '0);
    run("R9 pow2 ignores N", mk(1'b0, 2, 200), 4, 0, '0);
    run("R8 hold linear", mk(1'b1, 0, 4), 5, 3, mk(1'b1, 0, 1));
    run("R8 hold mode", mk(1'b0, 3, 0), 8, 2, mk(1'b1, 0, 0));
    run("R8 new cfg used", mk(1'b1, 0, 1), 2, 0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule